// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Controller

This block issues periodic refresh pulses for pseudo-static RAM and fits them around the external bus cycles that the CPU side requests. A divider counts system clocks. The length of the interval comes from a 2-bit period field. When the interval runs out, one refresh request is latched and held until it can be issued. A refresh is issued as a pulse of a fixed number of clocks on `ref_pulse`.

An 8-bit area mask sorts the 20-bit access address into eight regions. Each region has one bit in the mask. For a region whose bit is 0, a refresh may run at the same time as an access to that region, and neither side waits. For a region whose bit is 1, refresh and access exclude each other in both directions. A latched refresh waits until an exclusive access reports completion. An exclusive access request is not granted while a refresh pulse is running or is about to run.

Software reaches the two configuration registers through a small write/read port. The CPU side asks for bus cycles with `acc_req` and `acc_addr`, receives `acc_grant`, and ends its access with `acc_done`.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: After a synchronous reset, both configuration registers read 0, and `ref_pulse` and `acc_grant` are low.
- R2: With `cfg_sel`=0 the port reaches the 8-bit area mask. With `cfg_sel`=1 it reaches the period field in bits [1:0], and the upper read bits are 0. A write takes effect on the next clock. `cfg_rdata` shows the selected register combinationally.
- R3: The period field sets the refresh interval: 00 gives 32 clocks, 01 gives 64, 10 gives 128, and 11 is treated as 00 and gives 32. A write to the period field restarts the divider and drops any refresh that has not yet been issued. With the bus idle, the next pulse rises P+2 cycles after the write cycle, where P is the interval. No pulse rises before then.
- R4: The address selects mask bit k. Bit 0 covers 00000h-03FFFh, bit 1 covers 04000h-07FFFh, bit 2 covers 08000h-0BFFFh and bit 3 covers 0C000h-0FFFFh. Bit 4 covers 10000h-1FFFFh, bit 5 covers 20000h-3FFFFh, bit 6 covers 40000h-7FFFFh and bit 7 covers 80000h-FFFFFh.
- R5: For an access to a region whose mask bit is 0, a refresh pulse is issued on time while the access is active. The access grant is not delayed by a refresh starting in the same cycle.
- R6: While an access to a region whose mask bit is 1 is active (from its grant up to the cycle in which `acc_done` is high), no refresh pulse rises. A refresh held back in this way rises in the cycle after `acc_done`.
- R7: `ref_pulse` is never high in a cycle in which an exclusive access is active.
- R8: If a latched refresh and a new exclusive access request are both ready in the same cycle, the refresh starts first. The grant is decided in the last cycle of the pulse and shows on `acc_grant` in the cycle after the pulse ends.
- R9: At most one refresh request is held. Intervals that expire while a request is still waiting add no further pulses.
- R10: Each refresh pulse lasts exactly REF_CYC clocks (2 by default).
- R11: With no refresh conflict, `acc_grant` is high for one cycle, in the cycle after the cycle in which `acc_req` is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 area mask, 1 period field |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| acc_req | input | 1 | CPU-side bus cycle request, held until granted |
| acc_addr | input | 20 | Address of the requested access |
| acc_done | input | 1 | One-cycle marker that the granted access has ended |
| acc_grant | output | 1 | One-cycle grant of the requested access |
| ref_pulse | output | 1 | Refresh pulse to the RAM |

## Verification
Every result has a fixed latency from the cycle in which the bench drives its stimulus:
- A register write shows on `cfg_rdata` one cycle later.
- An uncontested grant shows one cycle after the request.
- After a period write in cycle W, the pulse rises in cycle W+P+2.
- A held-back refresh rises one cycle after `acc_done`.
- A grant that lost a tie shows REF_CYC+1 cycles after the request.

The bench keeps its own cycle counter. It records the cycle of each write and waits for the exact cycle before it samples. All samples are taken on the falling edge. It also counts rising pulse edges over whole windows, which shows that no pulse is early and no pulse is queued.

// File: rtl/psram_refresh_pkg.sv
package psram_refresh_pkg;

    localparam int ADDR_W      = 20;
    localparam int NUM_REGIONS = 8;
    localparam int REG_W       = 8;

    typedef enum logic [1:0] {
        PER_BASE   = 2'b00,
        PER_DOUBLE = 2'b01,
        PER_QUAD   = 2'b10,
        PER_RSVD   = 2'b11
    } period_sel_e;

    typedef struct packed {
        logic busy;
        logic excl;
    } acc_state_t;

    // Interval in clocks for a period selection; the reserved code falls back to base.
    function automatic int unsigned period_clocks(period_sel_e sel, int unsigned base);
        case (sel)
            PER_DOUBLE: return base * 2;
            PER_QUAD:   return base * 4;
            default:    return base;
        endcase
    endfunction

    // Lowest address of region k: four 16 KiB blocks, then blocks doubling in size.
    function automatic logic [ADDR_W-1:0] region_base(int k);
        if (k < 4) return ADDR_W'(k * 32'h4000);
        return ADDR_W'(32'h10000 << (k - 4));
    endfunction

    // Region index of an address: highest region whose base is not above it.
    function automatic logic [$clog2(NUM_REGIONS)-1:0] region_of(logic [ADDR_W-1:0] a);
        logic [$clog2(NUM_REGIONS)-1:0] r;
        r = '0;
        for (int k = 1; k < NUM_REGIONS; k++) begin
            if (a >= region_base(k)) r = k[$clog2(NUM_REGIONS)-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/psram_refresh_regs.sv
module psram_refresh_regs
    import psram_refresh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [NUM_REGIONS-1:0] area_mask,
    output period_sel_e       period_sel,
    output logic              period_wr
);

    logic [NUM_REGIONS-1:0] mask_q;
    period_sel_e            per_q;

    assign period_wr = cfg_wr_en && cfg_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            per_q  <= PER_BASE;
        end else if (cfg_wr_en) begin
            if (cfg_sel) per_q  <= period_sel_e'(cfg_wdata[1:0]);
            else         mask_q <= cfg_wdata[NUM_REGIONS-1:0];
        end
    end

    always_comb begin
        if (cfg_sel) cfg_rdata = {{(REG_W-2){1'b0}}, per_q};
        else         cfg_rdata = REG_W'(mask_q);
    end

    assign area_mask  = mask_q;
    assign period_sel = per_q;

    AST_RESET_VALUES: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0 && per_q == PER_BASE)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr_en) && !$past(cfg_sel)) |-> (mask_q == $past(cfg_wdata[NUM_REGIONS-1:0]))); // R2

endmodule

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer
    import psram_refresh_pkg::*;
#(
    parameter int BASE_PERIOD = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  period_sel_e period_sel,
    input  logic        restart,
    input  logic        consume,
    output logic        ref_pend
);

    localparam int MAX_PERIOD = BASE_PERIOD * 4;
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             tick;
    logic             pend_q;

    always_comb begin
        limit = CNT_W'(period_clocks(period_sel, BASE_PERIOD) - 1);
        tick  = (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt_q <= '0;
        else if (tick)       cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // Single pending slot: a fresh expiry overrides a same-cycle consume, never stacks.
    always_ff @(posedge clk) begin
        if (rst || restart)  pend_q <= 1'b0;
        else if (tick)       pend_q <= 1'b1;
        else if (consume)    pend_q <= 1'b0;
    end

    assign ref_pend = pend_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit); // R3

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume && !restart) |=> pend_q); // R9

endmodule

// File: rtl/psram_refresh_arb.sv
module psram_refresh_arb
    import psram_refresh_pkg::*;
#(
    parameter int REF_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ref_pend,
    input  logic [NUM_REGIONS-1:0] area_mask,
    input  logic                   acc_req,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_done,
    output logic                   acc_grant,
    output logic                   ref_pulse,
    output logic                   start_ref
);

    localparam int RC_W = $clog2(REF_CYC + 1);

    logic [RC_W-1:0] ref_left_q;
    logic            ref_busy;
    logic            ref_last;
    logic            ref_next;
    acc_state_t      acc_q;
    logic            grant_q;
    logic            req_excl;
    logic            excl_block;
    logic            grant_d;

    always_comb begin
        req_excl   = area_mask[region_of(acc_addr)];
        ref_busy   = (ref_left_q != '0);
        ref_last   = (ref_left_q == RC_W'(1));
        excl_block = acc_q.busy && acc_q.excl && !acc_done;
        start_ref  = ref_pend && !ref_busy && !excl_block;
        // Refresh will drive the pulse in the next cycle
        ref_next   = start_ref || (ref_busy && !ref_last);
        grant_d    = acc_req && !acc_q.busy && !(req_excl && ref_next);
    end

    always_ff @(posedge clk) begin
        if (rst)             ref_left_q <= '0;
        else if (start_ref)  ref_left_q <= RC_W'(REF_CYC);
        else if (ref_busy)   ref_left_q <= ref_left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            grant_q <= 1'b0;
        end else begin
            grant_q <= grant_d;
            if (grant_d) begin
                acc_q.busy <= 1'b1;
                acc_q.excl <= req_excl;
            end else if (acc_done) begin
                acc_q.busy <= 1'b0;
                acc_q.excl <= 1'b0;
            end
        end
    end

    assign acc_grant = grant_q;
    assign ref_pulse = ref_busy;

    AST_EXCL_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(ref_busy && acc_q.busy && acc_q.excl)); // R7

    AST_EXCL_HOLDS_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (acc_q.busy && acc_q.excl && !acc_done) |=> !$rose(ref_busy)); // R6

    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        grant_q |-> $past(acc_req)); // R11

    AST_TIE_REFRESH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ref_pend && !ref_busy && !excl_block && acc_req && req_excl && !acc_q.busy)
        |=> (ref_busy && !grant_q)); // R8

    AST_PULSE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_busy) |-> $past(ref_pend)); // R9

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
    import psram_refresh_pkg::*;
#(
    parameter int BASE_PERIOD = 32,
    parameter int REF_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_req,
    input  logic [19:0]       acc_addr,
    input  logic              acc_done,
    output logic              acc_grant,
    output logic              ref_pulse
);

    logic [NUM_REGIONS-1:0] area_mask;
    period_sel_e            period_sel;
    logic                   period_wr;
    logic                   ref_pend;
    logic                   start_ref;

    psram_refresh_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .area_mask  (area_mask),
        .period_sel (period_sel),
        .period_wr  (period_wr)
    );

    psram_refresh_timer #(.BASE_PERIOD(BASE_PERIOD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_sel (period_sel),
        .restart    (period_wr),
        .consume    (start_ref),
        .ref_pend   (ref_pend)
    );

    psram_refresh_arb #(.REF_CYC(REF_CYC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .ref_pend   (ref_pend),
        .area_mask  (area_mask),
        .acc_req    (acc_req),
        .acc_addr   (acc_addr),
        .acc_done   (acc_done),
        .acc_grant  (acc_grant),
        .ref_pulse  (ref_pulse),
        .start_ref  (start_ref)
    );

endmodule

// File: tb/psram_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module psram_refresh_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        acc_req = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_done = 1'b0;
    logic        acc_grant;
    logic        ref_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psram_refresh_ctrl u_psram_refresh_ctrl (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
        .acc_addr(acc_addr), .acc_done(acc_done), .acc_grant(acc_grant),
        .ref_pulse(ref_pulse)
    );

    // period code, expected interval
    localparam int NPER = 4;
    localparam int PER_TAB [NPER][2] = '{'{0, 32}, '{1, 64}, '{2, 128}, '{3, 32}};
    // address, expected region bit
    localparam int NREG = 16;
    localparam int REG_TAB [NREG][2] = '{
        '{32'h00000, 0}, '{32'h03FFF, 0}, '{32'h04000, 1}, '{32'h07FFF, 1},
        '{32'h08000, 2}, '{32'h0BFFF, 2}, '{32'h0C000, 3}, '{32'h0FFFF, 3},
        '{32'h10000, 4}, '{32'h1FFFF, 4}, '{32'h20000, 5}, '{32'h3FFFF, 5},
        '{32'h40000, 6}, '{32'h7FFFF, 6}, '{32'h80000, 7}, '{32'hFFFFF, 7}};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic sel, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_wr_en = 1'b0;
    endtask

    task automatic get_grant(input logic [19:0] a);
        acc_req = 1'b1; acc_addr = a;
        for (int i = 0; i < 200 && !acc_grant; i++) step();
        while (!acc_grant) step();
        acc_req = 1'b0;
    endtask

    task automatic finish_access();
        acc_done = 1'b1; step(); acc_done = 1'b0;
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int w, rises;
        logic prev;
        repeat (3) step();
        // R1 reset state
        check("R1 pulse", ref_pulse, 0);
        check("R1 grant", acc_grant, 0);
        rst = 1'b0;
        cfg_sel = 1'b0; #0; check("R1 mask read", cfg_rdata, 0);
        cfg_sel = 1'b1; #0; check("R1 period read", cfg_rdata, 0);

        // R2 register port
        wr_cfg(1'b0, 8'hA5); cfg_sel = 1'b0; #0; check("R2 mask readback", cfg_rdata, 8'hA5);
        wr_cfg(1'b1, 8'hFE); cfg_sel = 1'b1; #0; check("R2 period readback", cfg_rdata, 2);

        // R11 uncontested grant latency
        wr_cfg(1'b1, 8'h00);
        acc_req = 1'b1; acc_addr = 20'h00100;
        check("R11 no grant same cycle", acc_grant, 0);
        step(); check("R11 grant next cycle", acc_grant, 1);
        acc_req = 1'b0;
        step(); check("R11 grant one cycle", acc_grant, 0);
        finish_access();

        // R3 interval table
        for (int t = 0; t < NPER; t++) begin
            wr_cfg(1'b1, 8'(PER_TAB[t][0]));
            w = cyc - 1;
            rises = 0; prev = ref_pulse;
            for (int c = w + 2; c <= w + PER_TAB[t][1] + 1; c++) begin
                wait_until(c);
                if (c >= w + 3 && ref_pulse && !prev) rises++;
                prev = ref_pulse;
            end
            check("R3 no early pulse", rises, 0);
            check("R3 low before due", ref_pulse, 0);
            step();
            check("R3 pulse due at P+2", ref_pulse, 1);
        end

        // R4/R5/R6 region table, each address probed exclusive and concurrent
        for (int t = 0; t < NREG * 2; t++) begin
            int idx; logic excl;
            idx = REG_TAB[t / 2][1];
            excl = (t % 2 == 0);
            wr_cfg(1'b0, excl ? 8'(1 << idx) : ~8'(1 << idx));
            wr_cfg(1'b1, 8'h00);
            w = cyc - 1;
            get_grant(20'(REG_TAB[t / 2][0]));
            wait_until(w + 34);
            check(excl ? "R4 R6 held during access" : "R4 R5 concurrent pulse",
                  ref_pulse, excl ? 0 : 1);
            wait_until(w + 40);
            finish_access();
            check(excl ? "R6 pulse after done" : "R5 no late pulse", ref_pulse, excl ? 1 : 0);
            repeat (3) step();
        end

        // R9/R10/R6/R7 long exclusive access spanning several intervals
        wr_cfg(1'b0, 8'hFF);
        wr_cfg(1'b1, 8'h00);
        w = cyc - 1;
        get_grant(20'h2_0000);
        rises = 0;
        while (cyc < w + 110) begin step(); if (ref_pulse) rises++; end
        check("R7 no pulse in exclusive access", rises, 0);
        finish_access();
        check("R6 pulse first cycle", ref_pulse, 1);
        step(); check("R10 pulse second cycle", ref_pulse, 1);
        step(); check("R10 pulse ends", ref_pulse, 0);
        rises = 0;
        while (cyc < w + 129) begin step(); if (ref_pulse) rises++; end
        check("R9 no queued pulse", rises, 0);
        step(); check("R9 next interval pulse", ref_pulse, 1);
        repeat (4) step();

        // R8 tie: exclusive request meets a ready refresh
        wr_cfg(1'b1, 8'h00);
        w = cyc - 1;
        wait_until(w + 33);
        acc_req = 1'b1; acc_addr = 20'h8_0000;
        step(); check("R8 refresh first", ref_pulse, 1); check("R8 grant held", acc_grant, 0);
        step(); check("R8 grant held in pulse", acc_grant, 0);
        step(); check("R8 grant after pulse", acc_grant, 1); check("R8 pulse over", ref_pulse, 0);
        acc_req = 1'b0;
        step(); finish_access();

        // R5 tie in a concurrent region: both in the same cycle
        wr_cfg(1'b0, 8'h00);
        wr_cfg(1'b1, 8'h00);
        w = cyc - 1;
        wait_until(w + 33);
        acc_req = 1'b1; acc_addr = 20'h8_0000;
        step(); check("R5 pulse with grant", ref_pulse, 1); check("R5 grant not delayed", acc_grant, 1);
        acc_req = 1'b0;
        step(); finish_access();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule